// File: doc/BRIEF.md
# Synchronized Multi-Channel PWM Timer

This block generates five pulse-width-modulated outputs from one shared 16-bit time base. A master section owns the only counter. The counter runs from zero up to a programmed period value and then wraps. Three duty compares belong to the master section. A slave compare section adds two more duty compares. The slave section has no count of its own and compares against the master's count, so all five edges stay phase-locked to one period boundary.

Software reaches the block through a plain write port with six register slots. Slot 0 holds the period. Slots 1 to 3 hold the master duties, and slots 4 and 5 hold the slave duties. While the timer is stopped, a write takes effect at once, so setup can happen in any order. While the timer runs, every write lands in a shadow buffer only. A write to slot 1 arms a batch reload, and this holds even when the written value equals the old one. At the next period match, all six shadow values move into the active compares in the same clock. A period-match interrupt pulse marks each period boundary.

Top module: `sync_pwm_timer`

## Requirements
- R1: While running, the shared count steps by one per clock from 0 up to the active period value P and then returns to 0, so one period lasts P+1 clocks.
- R2: Output k (k = 0..4) is high while the count is less than the active duty value of slot k+1 and low for the rest of the period. Slots 1, 2 and 3 drive outputs 0, 1 and 2. Slots 4 and 5 drive outputs 3 and 4.
- R3: A duty value of 0 keeps its output low for the whole period. A duty value greater than P keeps its output high for the whole period.
- R4: `periodIrq` is high for exactly one clock per period, in the clock where the count equals P.
- R5: While running, a write to any slot changes only that slot's shadow buffer. The outputs and the period keep their active values until a batch reload happens.
- R6: A write to slot 1 while running arms a reload. At the next period match, all six shadow values (period and five duties) become active together, starting with the following period. Without an armed reload, no shadow value is ever transferred while running.
- R7: A write to slot 1 with the value it already holds still arms the reload.
- R8: The timer runs only when `masterEnable` = 1, `masterMode` = 3'b100 and `masterSel` = 4'b0000. In any other case, from the next clock on, the count is 0, all outputs are low and `periodIrq` is low. Reset gives the same state.
- R9: Outputs 3 and 4 follow the master count only when `slaveMode` = 3'b101, `slaveSync` = 1 and `slaveSel` = 2'b00. Otherwise those two outputs stay low, and outputs 0 to 2 are not affected.
- R10: While the timer is stopped, a write to any slot updates the active value directly. Slots may therefore be set up in any order before the timer is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEnable | input | 1 | Starts (1) or stops (0) the shared count |
| masterMode | input | 3 | Master mode field; 3'b100 selects PWM output |
| masterSel | input | 4 | Master capture/compare selects; all must be 0 (compare) |
| slaveMode | input | 3 | Slave mode field; 3'b101 selects counting from the master's count |
| slaveSync | input | 1 | Slave sync enable; must be 1 |
| slaveSel | input | 2 | Slave capture/compare selects; all must be 0 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Slot: 0 period, 1-3 master duties, 4-5 slave duties |
| wrData | input | 16 | Write data |
| pwmOut | output | 5 | PWM outputs; bits 0-2 master, bits 3-4 slave |
| periodIrq | output | 1 | Period-match interrupt pulse |

## Verification
A table of period and duty sets is loaded while the timer is stopped, and each set is run for one full period. The high time of each output and the position of the interrupt in that period are checked. The sets include a period of zero, duties of zero, duties equal to the period and duties above it, which separates the strict less-than compare from off-by-one variants. Directed runs then rewrite a duty while the timer runs without arming, then re-arm with an unchanged value, then change the period. These runs tell a correct batch reload apart from immediate writes, from reloads that ignore the arm, and from an arm that needs a changed value. The last runs break the master and slave mode fields one at a time, to show that each field gates only its own outputs.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic loadDirect;  // timer stopped: writes land in active registers at once
    logic commit;      // armed period match: shadow values become active
    logic slaveGate;   // slave compare section configured to follow the master
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import sync_pwm_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int ADDR_W   = 3,
  parameter int ARM_SLOT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEnable,
  input  logic [2:0]        masterMode,
  input  logic [3:0]        masterSel,
  input  logic [2:0]        slaveMode,
  input  logic              slaveSync,
  input  logic [1:0]        slaveSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  activeCycle,
  output logic [WIDTH-1:0]  count,
  output logic              running,
  output logic              periodMatch,
  output pwm_strobe_t       strobe
);
  localparam logic [2:0] MODE_PWM    = 3'b100;
  localparam logic [2:0] MODE_FOLLOW = 3'b101;

  logic runReq;
  logic runQ;
  logic armed;
  logic armWrite;

  assign runReq   = masterEnable && (masterMode == MODE_PWM) && (masterSel == 4'b0000);
  assign armWrite = wrEn && (wrAddr == ADDR_W'(ARM_SLOT));

  assign running     = runQ;
  assign periodMatch = runQ && (count == activeCycle);

  assign strobe.loadDirect = !runQ;
  assign strobe.commit     = periodMatch && armed;
  assign strobe.slaveGate  = (slaveMode == MODE_FOLLOW) && slaveSync && (slaveSel == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      count <= '0;
      armed <= 1'b0;
    end else begin
      runQ <= runReq;
      if (!runReq || !runQ) begin
        count <= '0;
      end else if (periodMatch) begin
        count <= '0;
      end else begin
        count <= count + 1'b1;
      end
      if (!runReq) begin
        armed <= 1'b0;
      end else if (armWrite) begin
        armed <= 1'b1;
      end else if (periodMatch) begin
        armed <= 1'b0;
      end
    end
  end

  // R1: the count never passes the active period
  p_count_in_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= activeCycle);

  // R1: a period match is followed by a count of zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    periodMatch |=> (count == '0));

  // R6: an arming write while running leaves the reload armed
  p_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armWrite && runReq) |=> armed);

  // R8: an invalid setup stops the count in the next clock
  p_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    !runReq |=> (count == '0) && !running && !periodMatch);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import sync_pwm_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int NUM_DUTY   = 5,
  parameter int NUM_MASTER = 3,
  parameter int ADDR_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WIDTH-1:0]    wrData,
  input  pwm_strobe_t         strobe,
  input  logic [WIDTH-1:0]    count,
  input  logic                running,
  output logic [WIDTH-1:0]    activeCycle,
  output logic [NUM_DUTY-1:0] pwmOut
);
  localparam int NUM_REGS = NUM_DUTY + 1;

  logic [WIDTH-1:0] bufQ    [NUM_REGS];
  logic [WIDTH-1:0] bufNext [NUM_REGS];
  logic [WIDTH-1:0] actQ    [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign bufNext[g] = (wrEn && (wrAddr == ADDR_W'(g))) ? wrData : bufQ[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufQ[g] <= '0;
        actQ[g] <= '0;
      end else begin
        bufQ[g] <= bufNext[g];
        if (strobe.loadDirect) begin
          actQ[g] <= bufNext[g];
        end else if (strobe.commit) begin
          actQ[g] <= bufQ[g];
        end
      end
    end

    // R5: while running, active values hold unless a reload commits
    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.loadDirect && !strobe.commit) |=> (actQ[g] == $past(actQ[g])));

    // R6: a commit copies the shadow value in one clock
    p_commit_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.commit |=> (actQ[g] == $past(bufQ[g])));
  end

  assign activeCycle = actQ[0];

  for (genvar d = 0; d < NUM_DUTY; d++) begin : g_out
    logic hit;
    assign hit = running && (count < actQ[d+1]);
    if (d < NUM_MASTER) begin : g_master
      assign pwmOut[d] = hit;
    end else begin : g_slave
      assign pwmOut[d] = hit && strobe.slaveGate;
    end
  end
endmodule

// File: rtl/sync_pwm_timer.sv
module sync_pwm_timer
  import sync_pwm_pkg::*;
#(
  parameter int  WIDTH      = 16,
  parameter int  NUM_DUTY   = 5,
  parameter int  NUM_MASTER = 3,
  localparam int ADDR_W     = $clog2(NUM_DUTY + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterEnable,
  input  logic [2:0]          masterMode,
  input  logic [3:0]          masterSel,
  input  logic [2:0]          slaveMode,
  input  logic                slaveSync,
  input  logic [1:0]          slaveSel,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WIDTH-1:0]    wrData,
  output logic [NUM_DUTY-1:0] pwmOut,
  output logic                periodIrq
);
  pwm_strobe_t      strobe;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] activeCycle;
  logic             running;

  pwm_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .ARM_SLOT(1)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .masterEnable(masterEnable), .masterMode(masterMode), .masterSel(masterSel),
    .slaveMode(slaveMode), .slaveSync(slaveSync), .slaveSel(slaveSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .activeCycle(activeCycle),
    .count(count), .running(running), .periodMatch(periodIrq), .strobe(strobe)
  );

  pwm_datapath #(.WIDTH(WIDTH), .NUM_DUTY(NUM_DUTY), .NUM_MASTER(NUM_MASTER),
                 .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .count(count), .running(running),
    .activeCycle(activeCycle), .pwmOut(pwmOut)
  );
endmodule

// File: tb/test_sync_pwm_timer.sv
module test_sync_pwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // per row: period, duty slots 1..5, expected high clocks of outputs 0..4
  localparam logic [15:0] VEC [NV][11] = '{
    '{16'd9,  16'd3, 16'd0,  16'd10, 16'd12, 16'd9, 16'd3, 16'd0,  16'd10, 16'd10, 16'd9},
    '{16'd4,  16'd1, 16'd2,  16'd5,  16'd4,  16'd0, 16'd1, 16'd2,  16'd5,  16'd4,  16'd0},
    '{16'd0,  16'd1, 16'd0,  16'd1,  16'd2,  16'd0, 16'd1, 16'd0,  16'd1,  16'd1,  16'd0},
    '{16'd15, 16'd8, 16'd15, 16'd16, 16'd1,  16'd7, 16'd8, 16'd15, 16'd16, 16'd1,  16'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterEnable = 1'b0;
  logic [2:0]  masterMode = 3'b100;
  logic [3:0]  masterSel = 4'b0000;
  logic [2:0]  slaveMode = 3'b101;
  logic        slaveSync = 1'b1;
  logic [1:0]  slaveSel = 2'b00;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [4:0]  pwmOut;
  logic        periodIrq;

  int checks = 0;
  int errors = 0;
  int highs [5];
  int irqCnt;
  logic irqLast;
  bit done = 1'b0;

  sync_pwm_timer i_sync_pwm_timer (
    .clk(clk), .rstN(rstN), .masterEnable(masterEnable), .masterMode(masterMode),
    .masterSel(masterSel), .slaveMode(slaveMode), .slaveSync(slaveSync),
    .slaveSel(slaveSel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .periodIrq(periodIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sampleWindow(input int n);
    for (int j = 0; j < 5; j++) highs[j] = 0;
    irqCnt = 0;
    irqLast = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 5; j++) highs[j] += int'(pwmOut[j]);
      irqCnt += int'(periodIrq);
      if (k == n - 1) irqLast = periodIrq;
      @(negedge clk);
    end
  endtask

  task automatic waitIrq();
    while (!periodIrq) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(pwmOut == 5'b0, "R8 reset outputs", int'(pwmOut), 0);
    check(periodIrq == 1'b0, "R8 reset irq", int'(periodIrq), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R10: table walk, slots written while stopped, slave slots first
    for (int v = 0; v < NV; v++) begin
      masterEnable = 1'b0;
      @(negedge clk);
      for (int s = 5; s >= 0; s--) wr(3'(s), VEC[v][s]);
      masterEnable = 1'b1;
      @(negedge clk);
      sampleWindow(int'(VEC[v][0]) + 1);
      for (int j = 0; j < 5; j++)
        check(highs[j] == int'(VEC[v][6+j]), $sformatf("R2 R3 R10 vec %0d out %0d", v, j),
              highs[j], int'(VEC[v][6+j]));
      check(irqCnt == 1 && irqLast, $sformatf("R4 R1 vec %0d irq count", v), irqCnt, 1);
      masterEnable = 1'b0;
    end

    // R5 R6 R7: batch reload while running
    @(negedge clk);
    wr(3'd0, 16'd9); wr(3'd1, 16'd3); wr(3'd2, 16'd4);
    wr(3'd3, 16'd5); wr(3'd4, 16'd6); wr(3'd5, 16'd7);
    masterEnable = 1'b1;
    @(negedge clk);
    wr(3'd2, 16'd8);
    waitIrq();
    sampleWindow(10);
    check(highs[1] == 4, "R5 unarmed write held in buffer", highs[1], 4);
    waitIrq();
    sampleWindow(10);
    check(highs[1] == 4, "R6 no transfer without arm", highs[1], 4);
    wr(3'd1, 16'd3);
    waitIrq();
    sampleWindow(10);
    check(highs[1] == 8, "R7 same-value arm commits", highs[1], 8);
    check(highs[0] == 3, "R6 out0 after commit", highs[0], 3);

    // R1 R3 R6: new period through the batch reload
    wr(3'd0, 16'd5); wr(3'd5, 16'd2); wr(3'd1, 16'd3);
    waitIrq();
    sampleWindow(6);
    check(irqCnt == 1 && irqLast, "R1 new period length 6", irqCnt, 1);
    check(highs[4] == 2, "R6 slave duty committed", highs[4], 2);
    check(highs[3] == 6, "R3 duty above period stays high", highs[3], 6);

    // R8: stop and invalid master setups
    masterEnable = 1'b0;
    @(negedge clk);
    sampleWindow(12);
    check(highs[0] + highs[1] + highs[2] + highs[3] + highs[4] == 0 && irqCnt == 0,
          "R8 disabled outputs low", highs[0] + irqCnt, 0);
    masterMode = 3'b101; masterEnable = 1'b1;
    @(negedge clk);
    sampleWindow(12);
    check(highs[0] + highs[3] + irqCnt == 0, "R8 wrong mode idle", highs[0] + irqCnt, 0);
    masterMode = 3'b100; masterSel = 4'b0010;
    @(negedge clk);
    sampleWindow(12);
    check(highs[0] + highs[3] + irqCnt == 0, "R8 capture select idle", highs[0] + irqCnt, 0);
    masterSel = 4'b0000;
    @(negedge clk);

    // R9: slave gating
    slaveSync = 1'b0;
    @(negedge clk);
    sampleWindow(6);
    check(highs[0] == 3, "R9 master unaffected", highs[0], 3);
    check(highs[3] + highs[4] == 0, "R9 slave low without sync", highs[3] + highs[4], 0);
    slaveSync = 1'b1; slaveMode = 3'b100;
    @(negedge clk);
    sampleWindow(6);
    check(highs[4] == 0, "R9 slave low with wrong mode", highs[4], 0);
    slaveMode = 3'b101; slaveSel = 2'b01;
    @(negedge clk);
    sampleWindow(6);
    check(highs[4] == 0, "R9 slave low with capture select", highs[4], 0);
    slaveSel = 2'b00;
    @(negedge clk);
    sampleWindow(6);
    check(highs[4] == 2, "R9 slave follows when configured", highs[4], 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule